// File: doc/BRIEF.md
# Masked Peripheral Interrupt Aggregator

This block collects ten peripheral interrupt requests into a sticky pending register and combines them into one interrupt line for the processor. Software controls the combination through a mask register. That register holds a global enable, a mode bit, and six group enables. The mode bit chooses whether the processor line is a high level or a one-cycle pulse on each rising edge of the combined request. The choice can change at run time. Pending bits stay set until software writes ones to clear them.

The block also has a small interrupt timer. A four-bit prescale value, capped at 14, sets a tick every 2^(prescale+1) clock cycles. A down-counter loaded from a register counts those ticks and pulses a done output when it reaches zero.

The register port is plain control: a write strobe, an address and write data. Read data is a combinational function of the address. There is no data stream and no back-pressure, so no valid/ready handshake is used.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all four registers read as zero, and `cpu_irq`, `tmr_tick` and `tmr_done` are low.
- R2: A source that is high at a clock edge sets its pending bit, which reads back at offset 0x04 and stays set after the source drops. The pending bit order is:
  - bits 0–3: GPIO banks A–D
  - bits 4–6: the three LED channels
  - bit 7: SPI
  - bit 8: SMBus
  - bit 9: one-wire
- R3: Writing to offset 0x04 clears every pending bit written as 1 and leaves the bits written as 0 unchanged. A source that is still high in the same cycle keeps its bit set.
- R4: While mask bit 0 (the global enable, at offset 0x00) is 0, `cpu_irq` stays low whatever is pending.
- R5: Each mask bit enables one group of pending bits:
  - mask bits 2–5 enable pending bits 0–3, one each
  - mask bit 6 enables pending bits 4–6
  - mask bit 7 enables pending bits 7–9
- R6: With mask bit 1 = 0 (level mode), `cpu_irq` is high exactly while some enabled pending bit is set. It follows a pending change one cycle after that pending change is visible.
- R7: With mask bit 1 = 1 (edge mode), `cpu_irq` is high for a single cycle when the combined masked request goes from low to high. It gives no further pulse while the request stays high.
- R8: A write to offset 0x08 stores bits 3:0 as the prescale, with values above 14 stored as 14, and bit 4 as the timer enable. Both read back in the same positions.
- R9: While the timer is enabled, `tmr_tick` is a one-cycle pulse every 2^(prescale+1) cycles. While it is disabled, `tmr_tick` stays low.
- R10: A write to offset 0x0C loads a tick down-counter that reads back at 0x0C. Each tick decrements it while it is non-zero. `tmr_done` pulses for one cycle when the counter reaches zero, and the counter then stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| src_irq | input | 10 | Peripheral interrupt requests |
| cpu_irq | output | 1 | Processor interrupt line |
| tmr_tick | output | 1 | Prescaled time-base tick |
| tmr_done | output | 1 | Down-counter expiry pulse |

## Verification
Each result has a fixed latency:
- A source sampled at edge k reads back as pending right after edge k.
- The processor line, in either mode, follows after edge k+1.
- A register write is visible right after its own edge.
- The done pulse appears one cycle after the tick that empties the counter.

The bench drives inputs on falling edges and samples on the falling edge at which each result is due. This places every check in the exact cycle named above rather than within a window. For the edge-mode checks, the bench also samples the cycle after the pulse, to show that the pulse lasts one cycle. For the timer, the bench measures tick-to-tick spacing, which does not depend on the prescaler's phase.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC  = 10;
  localparam int N_GRP  = 6;
  localparam int DATA_W = 16;
  localparam int PRE_W  = 4;
  localparam int PRE_MAX = 14;
  localparam int CNT_W  = PRE_MAX + 1;

  // Source-to-group map: four GPIO banks alone, LEDs together, serial together.
  function automatic int src_group(input int idx);
    if (idx < 4) return idx;
    else if (idx < 7) return 4;
    else return 5;
  endfunction

  typedef enum logic [1:0] {
    RA_MASK = 2'd0,
    RA_PEND = 2'd1,
    RA_PRE  = 2'd2,
    RA_TSET = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                  pend[i] <= 1'b0;
      else if (src[i])             pend[i] <= 1'b1;
      else if (clr_we && clr_bits[i]) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_group_gate.sv
module irq_group_gate
  import irq_pkg::*;
#(
  parameter int N = N_SRC,
  parameter int G = N_GRP
) (
  input  logic [N-1:0] pend,
  input  logic [G-1:0] grp_en,
  input  logic         glb_en,
  output logic         any_req
);
  logic [G-1:0] grp_pend;

  always_comb begin
    grp_pend = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) grp_pend[src_group(i)] = 1'b1;
    end
  end

  assign any_req = glb_en & |(grp_pend & grp_en);
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic edge_mode,
  output logic cpu_irq
);
  logic req_q, req_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      req_d <= 1'b0;
    end else begin
      req_q <= any_req;
      req_d <= req_q;
    end
  end

  assign cpu_irq = edge_mode ? (req_q & ~req_d) : req_q;
endmodule

// File: rtl/irq_timebase.sv
module irq_timebase
  import irq_pkg::*;
#(
  parameter int PW   = PRE_W,
  parameter int PMAX = PRE_MAX,
  parameter int TW   = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [PW:0]   cfg_wdata,
  input  logic          set_we,
  input  logic [TW-1:0] set_wdata,
  output logic [PW-1:0] pre_q,
  output logic          en_q,
  output logic [TW-1:0] tcount,
  output logic          tick,
  output logic          done
);
  localparam int CW = PMAX + 1;

  logic [CW-1:0] pre_cnt;
  logic [CW-1:0] lim;
  logic [PW-1:0] pre_in;

  assign pre_in = (int'(cfg_wdata[PW-1:0]) > PMAX) ? PW'(PMAX) : cfg_wdata[PW-1:0];
  assign lim    = CW'((CW+1)'(1) << (int'(pre_q) + 1)) - CW'(1);
  assign tick   = en_q && (pre_cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      en_q    <= 1'b0;
      pre_cnt <= '0;
    end else if (cfg_we) begin
      pre_q   <= pre_in;
      en_q    <= cfg_wdata[PW];
      pre_cnt <= '0;
    end else if (!en_q || tick) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcount <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (set_we) begin
        tcount <= set_wdata;
      end else if (tick && tcount != '0) begin
        tcount <= tcount - TW'(1);
        done   <= (tcount == TW'(1));
      end
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0]  src_irq,
  output logic              cpu_irq,
  output logic              tmr_tick,
  output logic              tmr_done
);
  localparam int MASK_W = N_GRP + 2;

  reg_sel_e            sel;
  logic [MASK_W-1:0]   mask_q;
  logic [N_SRC-1:0]    pend;
  logic                any_req;
  logic [PRE_W-1:0]    pre_q;
  logic                en_q;
  logic [DATA_W-1:0]   tcount;
  logic                unused_bits;

  assign sel = reg_sel_e'(reg_addr[3:2]);
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[DATA_W-1:MASK_W]};

  always_ff @(posedge clk) begin
    if (!rst_n)                        mask_q <= '0;
    else if (reg_wr && sel == RA_MASK) mask_q <= reg_wdata[MASK_W-1:0];
  end

  irq_status_bank #(.N(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src(src_irq),
    .clr_we(reg_wr && sel == RA_PEND),
    .clr_bits(reg_wdata[N_SRC-1:0]),
    .pend(pend)
  );

  irq_group_gate #(.N(N_SRC), .G(N_GRP)) u_gate (
    .pend(pend), .grp_en(mask_q[MASK_W-1:2]), .glb_en(mask_q[0]),
    .any_req(any_req)
  );

  irq_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .any_req(any_req),
    .edge_mode(mask_q[1]), .cpu_irq(cpu_irq)
  );

  irq_timebase u_tmr (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(reg_wr && sel == RA_PRE), .cfg_wdata(reg_wdata[PRE_W:0]),
    .set_we(reg_wr && sel == RA_TSET), .set_wdata(reg_wdata),
    .pre_q(pre_q), .en_q(en_q), .tcount(tcount),
    .tick(tmr_tick), .done(tmr_done)
  );

  always_comb begin
    unique case (sel)
      RA_MASK: reg_rdata = DATA_W'(mask_q);
      RA_PEND: reg_rdata = DATA_W'(pend);
      RA_PRE:  reg_rdata = DATA_W'({en_q, pre_q});
      default: reg_rdata = tcount;
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_irq,
  input logic [N_SRC-1:0] pend,
  input logic [7:0]       mask_q,
  input logic             cpu_irq,
  input logic             tmr_tick,
  input logic             tmr_done,
  input logic             en_q,
  input logic [PRE_W-1:0] pre_q,
  input logic [DATA_W-1:0] tcount
);
  a_r2_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (src_irq != '0) |=> ((pend & $past(src_irq)) == $past(src_irq)));

  a_r4_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[0] && $past(!mask_q[0]) && $past(rst_n)) |-> !cpu_irq);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[1] && cpu_irq) |=> (!cpu_irq || !mask_q[1]));

  a_r8_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_q) <= PRE_MAX);

  a_r9_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |-> en_q);

  a_r10_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |-> (tcount == '0));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .pend(pend), .mask_q(mask_q),
  .cpu_irq(cpu_irq), .tmr_tick(tmr_tick), .tmr_done(tmr_done),
  .en_q(en_q), .pre_q(pre_q), .tcount(tcount)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [9:0]  src_irq = '0;
  logic        cpu_irq, tmr_tick, tmr_done;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_irq(src_irq),
    .cpu_irq(cpu_irq), .tmr_tick(tmr_tick), .tmr_done(tmr_done)
  );

  // {mask[7:0], src[9:0], expected level}
  localparam logic [18:0] VEC [12] = '{
    {8'h00, 10'h3FF, 1'b0}, {8'hFE, 10'h3FF, 1'b0},
    {8'h05, 10'h001, 1'b1}, {8'h05, 10'h002, 1'b0},
    {8'h09, 10'h002, 1'b1}, {8'h11, 10'h004, 1'b1},
    {8'h21, 10'h008, 1'b1}, {8'h41, 10'h020, 1'b1},
    {8'h41, 10'h080, 1'b0}, {8'h81, 10'h200, 1'b1},
    {8'h81, 10'h10F, 1'b1}, {8'h3D, 10'h3F0, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.1 d = reg_rdata;
  endtask

  task automatic pulse_src(input logic [9:0] s);
    @(negedge clk);
    src_irq = s;
    @(negedge clk);
    src_irq = '0;
  endtask

  task automatic wait_tick(output int ok);
    ok = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (tmr_tick) begin ok = 1; break; end
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int ok, gap, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), d);
      chk("R1 reg", d, 16'h0);
    end
    chk("R1 outs", {13'b0, cpu_irq, tmr_tick, tmr_done}, 16'h0);

    // R4 R5 R6 table: level mode, one vector per pass
    for (int v = 0; v < 12; v++) begin
      wr(4'h4, 16'h03FF);
      wr(4'h0, {8'h00, VEC[v][18:11]});
      pulse_src(VEC[v][10:1]);
      @(negedge clk);
      chk($sformatf("R5 R4 vec%0d", v), {15'b0, cpu_irq}, {15'b0, VEC[v][0]});
    end

    // R2 capture and bit order
    wr(4'h0, 16'h0000);
    wr(4'h4, 16'h03FF);
    pulse_src(10'h2A5);
    rd(4'h4, d);
    chk("R2 pend", d, 16'h02A5);
    // R3 write-one-to-clear
    wr(4'h4, 16'h0005);
    rd(4'h4, d);
    chk("R3 partial clear", d, 16'h02A0);
    // R3 set beats clear
    @(negedge clk);
    src_irq = 10'h200;
    reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 16'h03FF;
    @(negedge clk);
    reg_wr = 1'b0; src_irq = '0;
    rd(4'h4, d);
    chk("R3 set wins", d, 16'h0200);

    // R6 level follows pending and drops one cycle after clear
    wr(4'h4, 16'h03FF);
    wr(4'h0, 16'h0005);
    pulse_src(10'h001);
    repeat (3) begin
      @(negedge clk);
      chk("R6 hold high", {15'b0, cpu_irq}, 16'h1);
    end
    wr(4'h4, 16'h0001);
    chk("R6 one cycle lag", {15'b0, cpu_irq}, 16'h1);
    @(negedge clk);
    chk("R6 low after clear", {15'b0, cpu_irq}, 16'h0);

    // R7 edge mode
    wr(4'h0, 16'h0007);
    pulse_src(10'h001);
    @(negedge clk);
    chk("R7 pulse", {15'b0, cpu_irq}, 16'h1);
    @(negedge clk);
    chk("R7 one cycle", {15'b0, cpu_irq}, 16'h0);
    pulse_src(10'h001);
    @(negedge clk);
    chk("R7 no repeat", {15'b0, cpu_irq}, 16'h0);
    wr(4'h4, 16'h03FF);

    // R8 clamp and readback
    wr(4'h8, 16'h001F);
    rd(4'h8, d);
    chk("R8 clamp", d, 16'h001E);
    wr(4'h8, 16'h000F);
    rd(4'h8, d);
    chk("R8 disabled clamp", d, 16'h000E);

    // R9 period for prescale 3 and 0
    wr(4'h8, 16'h0013);
    wait_tick(ok);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tmr_tick && gap < 100);
    chk("R9 period p3", 16'(gap), 16'd16);
    wr(4'h8, 16'h0010);
    wait_tick(ok);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tmr_tick && gap < 100);
    chk("R9 period p0", 16'(gap), 16'd2);
    wr(4'h8, 16'h0003);
    seen = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (tmr_tick) seen++;
    end
    chk("R9 disabled", 16'(seen), 16'd0);

    // R10 down-counter
    wr(4'hC, 16'h0003);
    rd(4'hC, d);
    chk("R10 load", d, 16'h0003);
    wr(4'h8, 16'h0010);
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tmr_done) seen++;
    end
    chk("R10 one done", 16'(seen), 16'd1);
    rd(4'hC, d);
    chk("R10 stays zero", d, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule